// File: doc/BRIEF.md
# Phase-Handshake Ring Pipeline Controller

This block models a closed ring of `K` dual-rail register stages that hand data to each other by a phase handshake. Each stage keeps a W-bit word as two rails: rail a carries the logical value, and the phase of the stage is rail a XOR rail b. A stage holds a *token* when the phase offered by its predecessor differs from its own phase. A stage with an identical phase is a *bubble*. A stage advances only when it holds a token and its successor is a bubble. It does so by copying the predecessor's rails, which also copies the predecessor's phase. The link that closes the ring from the last stage back to stage 0 passes through a phase inverter. When enabled, the inverter flips rail b. This changes the phase of the returning word and leaves its value alone.

The controller evaluates every stage once per clock, and all decisions use the state from before the edge. While reset is held, it loads one of four start-up patterns and sets the inverter so that the chosen pattern has the intended number of tokens. One pattern leaves the inverter off on an all-equal ring, so a stalled ring can be studied. The ports expose each stage's phase, value and firing, a running fire count per stage, the number of tokens in the ring, and a flag that reports a ring that has stopped.

Top module: `bubble_ring`

## Requirements
- R1: `init_mode` is sampled on every clock edge where `rst` is high. Its encodings are: 0 = empty, where all phases are 0 and the inverter is on; 1 = full, where stage i has phase i mod 2 and the inverter is on exactly when K is even; 2 = spread, where tokens sit at the even-numbered stages; 3 = uninverted, where all phases are 0 and the inverter is off. In every mode, reset clears `stage_fire`, all fire counts and `deadlock`.
- R2: Stage i holds a token when its input phase differs from its own phase. The input phase of stage i>0 is the phase of stage i-1; for stage 0 it is the phase of stage K-1 passed through the inverter. `token_count` equals the number of tokens: 1 when empty, K-1 when full, ceil(K/2) when spread, 0 when uninverted. This count never changes between resets, and its parity equals the inverter setting.
- R3: On each edge, stage i fires if and only if it holds a token and its successor (stage (i+1) mod K) does not. When a stage fires, its phase toggles, and `stage_fire[i]` is high for the cycle after that edge. Two neighbouring stages never fire on the same edge.
- R4: When the inverter is on, stage 0 takes the phase of stage K-1 inverted. In empty mode, K edges after reset every phase is 1.
- R5: At reset, stage i holds value i mod 2^W. A stage that fires takes its predecessor's value unchanged, and this includes stage 0 taking the value of stage K-1. Values are packed with stage i at bits [i*W +: W] of `stage_value`.
- R6: `fire_count[i*CW +: CW]` counts the edges on which stage i fired, modulo 2^CW.
- R7: `deadlock` goes high on the K-th consecutive edge with no firing stage, and is low otherwise.
- R8: In empty and full modes each stage fires once every K edges. In spread mode with K even, every stage fires once every 2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the start pattern |
| init_mode | input | 2 | Start pattern selector, sampled during reset |
| stage_phase | output | K | Phase of each stage |
| stage_fire | output | K | Stages that fired on the last edge |
| stage_value | output | K*W | Logical value of each stage |
| token_count | output | $clog2(K+1) | Tokens in the ring |
| fire_count | output | K*CW | Per-stage fire counters |
| deadlock | output | 1 | Ring has not moved for K edges |

## Verification
The bench builds two copies side by side. The first has K=6, which is even, so the full pattern needs the inverter and the spread pattern gives the maximum rate of one fire every two edges per stage. The second has K=5, which is odd, so the full pattern runs with the inverter off and in the spread pattern two tokens touch across the wrap link. Both copies use W=4 and CW=8. The 8-bit counters let a run of about 1500 cycles reach counter wrap. The small W makes stage indices fold into visible values.

// File: rtl/bubble_ring_pkg.sv
package bubble_ring_pkg;
  typedef enum logic [1:0] {
    START_EMPTY  = 2'd0,
    START_FULL   = 2'd1,
    START_SPREAD = 2'd2,
    START_NOINV  = 2'd3
  } start_mode_e;
endpackage

// File: rtl/ring_phase_flip.sv
module ring_phase_flip #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);
  assign out_a = in_a;
  assign out_b = in_b ^ {W{en}};
endmodule

// File: rtl/ring_stage.sv
module ring_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] init_a,
  input  logic [W-1:0] init_b,
  input  logic [W-1:0] pred_a,
  input  logic [W-1:0] pred_b,
  input  logic         succ_full,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b,
  output logic         phase,
  output logic         full,
  output logic         fire
);
  logic pred_phase;

  assign pred_phase = pred_a[0] ^ pred_b[0];
  assign phase      = q_a[0] ^ q_b[0];
  assign full       = pred_phase ^ phase;
  assign fire       = full & ~succ_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= init_a;
      q_b <= init_b;
    end else if (fire) begin
      q_a <= pred_a;
      q_b <= pred_b;
    end
  end

  // R5
  rails_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    (((q_a ^ q_b) == '0) || ((q_a ^ q_b) == '1)));
endmodule

// File: rtl/ring_monitor.sv
module ring_monitor #(
  parameter int K  = 4,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [K-1:0]    fire,
  input  logic [K-1:0]    full,
  input  logic [K-1:0]    init_map,
  output logic [K-1:0]    fire_q,
  output logic [$clog2(K+1)-1:0] token_q,
  output logic [K*CW-1:0] count_flat,
  output logic            dead_q
);
  localparam int TW = $clog2(K+1);

  function automatic logic [TW-1:0] ones(input logic [K-1:0] v);
    logic [TW-1:0] n;
    n = '0;
    for (int i = 0; i < K; i++) n = n + TW'(v[i]);
    return n;
  endfunction

  logic [TW-1:0] idle_q, idle_nx;
  logic          live_q;

  assign idle_nx = (|fire) ? '0 : ((idle_q == TW'(K)) ? idle_q : idle_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q  <= '0;
      token_q <= ones(init_map);
      idle_q  <= '0;
      dead_q  <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      fire_q  <= fire;
      token_q <= ones(full);
      idle_q  <= idle_nx;
      dead_q  <= (idle_nx == TW'(K));
      live_q  <= 1'b1;
    end
  end

  for (genvar g = 0; g < K; g++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + CW'(fire[g]);
    end
    assign count_flat[g*CW +: CW] = cnt_q;
  end

  // R2
  token_stable_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> $stable(token_q));
  // R7
  dead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dead_q |-> (fire_q == '0));
endmodule

// File: rtl/bubble_ring.sv
module bubble_ring
  import bubble_ring_pkg::*;
#(
  parameter int K  = 4,
  parameter int W  = 8,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             init_mode,
  output logic [K-1:0]           stage_phase,
  output logic [K-1:0]           stage_fire,
  output logic [K*W-1:0]         stage_value,
  output logic [$clog2(K+1)-1:0] token_count,
  output logic [K*CW-1:0]        fire_count,
  output logic                   deadlock
);
  localparam int TW = $clog2(K+1);

  function automatic logic [K-1:0] token_map(input start_mode_e m);
    logic [K-1:0] t;
    for (int i = 0; i < K; i++) begin
      case (m)
        START_EMPTY:  t[i] = (i == 0);
        START_FULL:   t[i] = (i != 0);
        START_SPREAD: t[i] = ((i % 2) == 0);
        default:      t[i] = 1'b0;
      endcase
    end
    return t;
  endfunction

  function automatic logic [K-1:0] phase_map(input logic [K-1:0] t);
    logic [K-1:0] p;
    p[0] = 1'b0;
    for (int i = 1; i < K; i++) p[i] = p[i-1] ^ t[i];
    return p;
  endfunction

  logic [K-1:0] start_tok, start_ph;
  logic         start_inv, inv_q, live_q;

  assign start_tok = token_map(start_mode_e'(init_mode));
  assign start_ph  = phase_map(start_tok);
  assign start_inv = start_ph[K-1] ^ start_tok[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q  <= start_inv;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  logic [W-1:0] ra   [K];
  logic [W-1:0] rb   [K];
  logic [W-1:0] loop_a, loop_b;
  logic [K-1:0] full, fire;

  ring_phase_flip #(.W(W)) u_flip (
    .en   (inv_q),
    .in_a (ra[K-1]),
    .in_b (rb[K-1]),
    .out_a(loop_a),
    .out_b(loop_b)
  );

  for (genvar g = 0; g < K; g++) begin : g_stage
    localparam logic [W-1:0] IDXV = W'(g);
    localparam int PRED = (g == 0) ? K - 1 : g - 1;
    localparam int SUCC = (g == K - 1) ? 0 : g + 1;
    logic [W-1:0] pa, pb;
    if (g == 0) begin : g_head
      assign pa = loop_a;
      assign pb = loop_b;
    end else begin : g_body
      assign pa = ra[PRED];
      assign pb = rb[PRED];
    end
    ring_stage #(.W(W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .init_a   (IDXV),
      .init_b   (IDXV ^ {W{start_ph[g]}}),
      .pred_a   (pa),
      .pred_b   (pb),
      .succ_full(full[SUCC]),
      .q_a      (ra[g]),
      .q_b      (rb[g]),
      .phase    (stage_phase[g]),
      .full     (full[g]),
      .fire     (fire[g])
    );
    assign stage_value[g*W +: W] = ra[g];
  end

  ring_monitor #(.K(K), .CW(CW)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .full      (full),
    .init_map  (start_tok),
    .fire_q    (stage_fire),
    .token_q   (token_count),
    .count_flat(fire_count),
    .dead_q    (deadlock)
  );

  // R3
  no_adjacent_fire_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((stage_fire & {stage_fire[0], stage_fire[K-1:1]}) == '0));
  // R3
  phase_moves_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((stage_phase ^ $past(stage_phase)) == stage_fire));
  // R2
  token_parity_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (token_count[0] == inv_q));
endmodule

// File: tb/bubble_ring_test.sv
module bubble_ring_test;
  localparam int KA = 6, KB = 5, W = 4, CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic cmp_en = 1'b0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  logic [KA-1:0] a_ph, a_fire;
  logic [KA*W-1:0] a_val;
  logic [2:0] a_tok;
  logic [KA*CW-1:0] a_cnt;
  logic a_dead;
  logic [KB-1:0] b_ph, b_fire;
  logic [KB*W-1:0] b_val;
  logic [2:0] b_tok;
  logic [KB*CW-1:0] b_cnt;
  logic b_dead;

  bubble_ring #(.K(KA), .W(W), .CW(CW)) uut (
    .clk(clk), .rst(rst), .init_mode(mode), .stage_phase(a_ph), .stage_fire(a_fire),
    .stage_value(a_val), .token_count(a_tok), .fire_count(a_cnt), .deadlock(a_dead));
  bubble_ring #(.K(KB), .W(W), .CW(CW)) uut_odd (
    .clk(clk), .rst(rst), .init_mode(mode), .stage_phase(b_ph), .stage_fire(b_fire),
    .stage_value(b_val), .token_count(b_tok), .fire_count(b_cnt), .deadlock(b_dead));

  // reference model, index 0 = K6, index 1 = K5
  int kk [2] = '{KA, KB};
  bit mph [2][8];
  bit mfire [2][8];
  logic [W-1:0] mval [2][8];
  logic [CW-1:0] mcnt [2][8];
  bit minv [2];
  int midle [2];
  bit mdead [2];
  int mtok [2];

  function automatic bit tok_at(int m, int i);
    case (m)
      0: return i == 0;
      1: return i != 0;
      2: return (i % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_reset(int d);
    int k = kk[d];
    bit p = 0;
    mtok[d] = 0;
    for (int i = 0; i < k; i++) begin
      if (i > 0) p = p ^ tok_at(mode, i);
      mph[d][i] = p;
      mval[d][i] = W'(i);
      mcnt[d][i] = '0;
      mfire[d][i] = 0;
      if (tok_at(mode, i)) mtok[d]++;
    end
    minv[d] = mph[d][k-1] ^ tok_at(mode, 0);
    midle[d] = 0;
    mdead[d] = 0;
  endtask

  task automatic m_step(int d);
    int k = kk[d];
    bit has [8];
    bit oph [8];
    logic [W-1:0] ov [8];
    bit any = 0;
    for (int i = 0; i < k; i++) begin
      oph[i] = mph[d][i];
      ov[i] = mval[d][i];
    end
    mtok[d] = 0;
    for (int i = 0; i < k; i++) begin
      has[i] = ((i == 0) ? (oph[k-1] ^ minv[d]) : oph[i-1]) != oph[i];
      if (has[i]) mtok[d]++;
    end
    for (int i = 0; i < k; i++) begin
      mfire[d][i] = has[i] && !has[(i + 1) % k];
      if (mfire[d][i]) begin
        any = 1;
        mph[d][i] = ~oph[i];
        mval[d][i] = ov[(i == 0) ? k - 1 : i - 1];
        mcnt[d][i] = mcnt[d][i] + 1'b1;
      end
    end
    if (any) midle[d] = 0;
    else if (midle[d] < k) midle[d]++;
    mdead[d] = (midle[d] == k);
  endtask

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) m_reset(d);
      else m_step(d);
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(int d, longint ph, longint fi, longint va, longint tk,
                         longint ct, bit dd);
    int k = kk[d];
    longint eph = 0, efi = 0, eva = 0, ect = 0;
    for (int i = 0; i < k; i++) begin
      eph |= longint'(mph[d][i]) << i;
      efi |= longint'(mfire[d][i]) << i;
      eva |= longint'(mval[d][i]) << (i * W);
      ect |= longint'(mcnt[d][i]) << (i * CW);
    end
    check(ph == eph, "R3", "stage phases", ph, eph);
    check(fi == efi, "R3", "stage fires", fi, efi);
    check(va == eva, "R5", "stage values", va, eva);
    check(tk == longint'(mtok[d]), "R2", "token count", tk, mtok[d]);
    check(ct == ect, "R6", "fire counts", ct, ect);
    check(dd == mdead[d], "R7", "deadlock", dd, mdead[d]);
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      compare(0, a_ph, a_fire, a_val, a_tok, a_cnt, a_dead);
      compare(1, b_ph, b_fire, b_val, b_tok, b_cnt, b_dead);
    end
  end

  task automatic do_reset(int m, int cycles);
    @(negedge clk);
    mode = 2'(m);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 empty start, R2 one token
    do_reset(0, 2);
    cmp_en = 1'b1;
    check(a_ph == 6'b000000, "R1", "empty phases", a_ph, 0);
    check(a_fire == 0 && a_cnt == 0 && !a_dead, "R1", "cleared outputs", a_cnt, 0);
    check(a_tok == 3'd1, "R2", "empty tokens", a_tok, 1);
    check(a_val == 24'h543210, "R5", "reset values", a_val, 24'h543210);
    run(6);
    // R4 after one full lap every phase flipped, value 5 carried round
    check(a_ph == 6'b111111, "R4", "phases after lap", a_ph, 6'b111111);
    check(a_val == 24'h555555, "R4", "values after lap", a_val, 24'h555555);
    run(6);
    for (int i = 0; i < KA; i++)
      check(a_cnt[i*CW +: CW] == 8'd2, "R8", "empty rate K6", a_cnt[i*CW +: CW], 2);

    // R1 full start
    do_reset(1, 1);
    check(a_ph == 6'b101010, "R1", "full phases K6", a_ph, 6'b101010);
    check(b_ph == 5'b01010, "R1", "full phases K5", b_ph, 5'b01010);
    check(a_tok == 3'd5 && b_tok == 3'd4, "R2", "full tokens", {a_tok, b_tok}, 6'o54);
    run(12);
    for (int i = 0; i < KA; i++)
      check(a_cnt[i*CW +: CW] == 8'd2, "R8", "full rate K6", a_cnt[i*CW +: CW], 2);

    // spread start: higher rate
    do_reset(2, 1);
    check(a_tok == 3'd3 && b_tok == 3'd3, "R2", "spread tokens", {a_tok, b_tok}, 6'o33);
    run(12);
    for (int i = 0; i < KA; i++)
      check(a_cnt[i*CW +: CW] == 8'd6, "R8", "spread rate K6", a_cnt[i*CW +: CW], 6);

    // uninverted: stalled ring
    do_reset(3, 1);
    check(a_tok == 0, "R2", "no tokens", a_tok, 0);
    run(4);
    check(!b_dead, "R7", "K5 early deadlock", b_dead, 0);
    run(1);
    check(b_dead, "R7", "K5 deadlock at K", b_dead, 1);
    check(!a_dead, "R7", "K6 early deadlock", a_dead, 0);
    run(1);
    check(a_dead && a_fire == 0, "R7", "K6 deadlock at K", a_dead, 1);

    // R6 counter wrap: 257 fires per stage
    do_reset(0, 1);
    run(257 * KA);
    for (int i = 0; i < KA; i++)
      check(a_cnt[i*CW +: CW] == 8'd1, "R6", "wrapped count", a_cnt[i*CW +: CW], 1);

    // random restarts
    for (int s = 0; s < 40; s++) begin
      do_reset($urandom_range(3, 0), $urandom_range(2, 1));
      run($urandom_range(80, 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule